// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle processor datapath that handles five instruction kinds: register-register arithmetic, OR-immediate, load word, store word and branch-if-equal. It is a Moore machine with thirteen states in a four-bit binary register. Each state sets the enables and selects for one step of an instruction. These steps are instruction fetch, operand fetch, execute, memory access and register write-back. The datapath supplies the 6-bit opcode of the latched instruction and the equality flag of the main ALU. The sequencer returns one control bundle per cycle.

The state code is brought out on a port so that surrounding logic and tests can follow the exact state sequence. The control outputs are registered. They are loaded from the decode of the next state, so they change on the same edge as the state code and stay aligned with it. Branches are resolved while in decode, and each branch outcome has its own terminal state. The program counter is written only in the last state of each instruction.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the state to 0000 on the next rising edge. The controls then show only `ir_en_o`=1, and every other control is 0.
- R2: State 0000 (fetch) asserts only `ir_en_o` and always moves to 0001. State 0001 (decode) asserts only `a_en_o` and `b_en_o`.
- R3: The next state out of 0001 depends on the opcode and the flag. Opcode 000000 (register type) goes to 0100. Opcode 001101 (OR immediate) goes to 0110. Opcode 100011 (load) goes to 1000. Opcode 101011 (store) goes to 1011. Opcode 000100 (branch) goes to 0010 when `zero_i`=1 and to 0011 when `zero_i`=0.
- R4: The state paths are 0100→0101, 0110→0111, 1000→1001→1010 and 1011→1100. Each of 0101, 0111, 1010, 1100, 0010 and 0011 returns to 0000.
- R5: State 0010 sets `pc_en_o`=1 and `pc_sel_o`=1 (branch target). States 0011, 0101, 0111, 1010 and 1100 set `pc_en_o`=1 and `pc_sel_o`=0 (sequential address). No other state sets `pc_en_o`.
- R6: Every execute state sets `r_en_o`=1. `alu_op_o` is encoded as 00 add, 01 OR, 10 function field. State 0100 sets `alu_op_o`=10 and `alu_imm_o`=0. State 0110 sets `alu_op_o`=01, `alu_imm_o`=1 and `ext_sign_o`=0 (zero extend). States 1000 and 1011 set `alu_op_o`=00, `alu_imm_o`=1 and `ext_sign_o`=1.
- R7: State 1001 asserts `mem_rd_o` and `m_en_o`. State 1100 asserts `mem_wr_o`.
- R8: State 0101 sets `reg_wr_o`=1, `mem_to_reg_o`=0 and `reg_dst_rd_o`=1. State 0111 sets `reg_wr_o`=1, `mem_to_reg_o`=0 and `reg_dst_rd_o`=0. State 1010 sets `reg_wr_o`=1, `mem_to_reg_o`=1 and `reg_dst_rd_o`=0.
- R9: Counted from fetch to the next fetch, an instruction takes 4 cycles for register type and OR immediate, 5 for load, 4 for store and 3 for branch.
- R10: Any other opcode in decode goes to 0000 on the next cycle, and the sequencer writes no register, memory or PC for it. The instruction therefore takes 2 cycles.
- R11: Any control that R1 to R8 do not list for a state is 0 in that state. All controls change on the same edge as `state_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the latched instruction |
| zero_i | input | 1 | ALU equality flag |
| state_o | output | 4 | Current state code |
| ir_en_o | output | 1 | Instruction register load |
| pc_en_o | output | 1 | Program counter load |
| pc_sel_o | output | 1 | PC source: 1 branch target, 0 sequential |
| a_en_o | output | 1 | Operand A register load |
| b_en_o | output | 1 | Operand B register load |
| ext_sign_o | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_imm_o | output | 1 | ALU second operand: 1 immediate, 0 register |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 OR, 10 function field |
| r_en_o | output | 1 | ALU result register load |
| mem_rd_o | output | 1 | Data memory read |
| m_en_o | output | 1 | Memory data register load |
| mem_wr_o | output | 1 | Data memory write |
| mem_to_reg_o | output | 1 | Write-back source: 1 memory data, 0 ALU result |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_rd_o | output | 1 | Destination field: 1 rd, 0 rt |

## Verification
A wrong state code shows on `state_o` in the same cycle. The control bundle that belongs to that state is registered alongside it, so a wrong state also shows as a wrong control pattern in that cycle. A transition error out of decode shows one cycle after decode, either as the wrong execute controls or as a premature return to fetch. That return also changes the measured instruction length. The sweep drives all 64 opcodes with both flag values and compares the state code and all sixteen control bits in every cycle of every instruction, so no decode entry or state goes unobserved.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH    = 4'h0,
    S_DECODE   = 4'h1,
    S_BR_TAKEN = 4'h2,
    S_BR_NOT   = 4'h3,
    S_RT_EX    = 4'h4,
    S_RT_WB    = 4'h5,
    S_OI_EX    = 4'h6,
    S_OI_WB    = 4'h7,
    S_LD_EX    = 4'h8,
    S_LD_MEM   = 4'h9,
    S_LD_WB    = 4'hA,
    S_ST_EX    = 4'hB,
    S_ST_MEM   = 4'hC
  } st_e;

  typedef enum logic [2:0] {
    CL_RT, CL_OI, CL_LD, CL_ST, CL_BR, CL_BAD
  } cls_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_OR    = 2'b01,
    ALU_FUNCT = 2'b10
  } alu_e;

  typedef struct packed {
    logic ir_en;
    logic pc_en;
    logic pc_sel;
    logic a_en;
    logic b_en;
    logic ext_sign;
    logic alu_imm;
    alu_e alu_op;
    logic r_en;
    logic mem_rd;
    logic m_en;
    logic mem_wr;
    logic mem_to_reg;
    logic reg_wr;
    logic reg_dst_rd;
  } ctrl_t;

endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
  import mcyc_pkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OPC_RT = 6'b000000,
  parameter logic [OP_W-1:0] OPC_OI = 6'b001101,
  parameter logic [OP_W-1:0] OPC_LD = 6'b100011,
  parameter logic [OP_W-1:0] OPC_ST = 6'b101011,
  parameter logic [OP_W-1:0] OPC_BR = 6'b000100
) (
  input  logic [OP_W-1:0] opcode_i,
  output cls_e            cls_o
);

  always_comb begin
    if      (opcode_i == OPC_RT) cls_o = CL_RT;
    else if (opcode_i == OPC_OI) cls_o = CL_OI;
    else if (opcode_i == OPC_LD) cls_o = CL_LD;
    else if (opcode_i == OPC_ST) cls_o = CL_ST;
    else if (opcode_i == OPC_BR) cls_o = CL_BR;
    else                         cls_o = CL_BAD;
  end

endmodule

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
(
  input  st_e  state_i,
  input  cls_e cls_i,
  input  logic zero_i,
  output st_e  next_o
);

  always_comb begin
    next_o = S_FETCH;
    case (state_i)
      S_FETCH:  next_o = S_DECODE;
      S_DECODE: begin
        case (cls_i)
          CL_RT:   next_o = S_RT_EX;
          CL_OI:   next_o = S_OI_EX;
          CL_LD:   next_o = S_LD_EX;
          CL_ST:   next_o = S_ST_EX;
          CL_BR:   next_o = zero_i ? S_BR_TAKEN : S_BR_NOT;
          default: next_o = S_FETCH;
        endcase
      end
      S_RT_EX:  next_o = S_RT_WB;
      S_OI_EX:  next_o = S_OI_WB;
      S_LD_EX:  next_o = S_LD_MEM;
      S_LD_MEM: next_o = S_LD_WB;
      S_ST_EX:  next_o = S_ST_MEM;
      default:  next_o = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_outdec.sv
module mcyc_outdec
  import mcyc_pkg::*;
(
  input  st_e   state_i,
  output ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (state_i)
      S_FETCH:  ctrl_o.ir_en = 1'b1;
      S_DECODE: begin
        ctrl_o.a_en = 1'b1;
        ctrl_o.b_en = 1'b1;
      end
      S_BR_TAKEN: begin
        ctrl_o.pc_en  = 1'b1;
        ctrl_o.pc_sel = 1'b1;
      end
      S_BR_NOT: ctrl_o.pc_en = 1'b1;
      S_RT_EX: begin
        ctrl_o.alu_op = ALU_FUNCT;
        ctrl_o.r_en   = 1'b1;
      end
      S_RT_WB: begin
        ctrl_o.pc_en      = 1'b1;
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.reg_dst_rd = 1'b1;
      end
      S_OI_EX: begin
        ctrl_o.alu_imm = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
        ctrl_o.r_en    = 1'b1;
      end
      S_OI_WB: begin
        ctrl_o.pc_en  = 1'b1;
        ctrl_o.reg_wr = 1'b1;
      end
      S_LD_EX, S_ST_EX: begin
        ctrl_o.alu_imm  = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.alu_op   = ALU_ADD;
        ctrl_o.r_en     = 1'b1;
      end
      S_LD_MEM: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.m_en   = 1'b1;
      end
      S_LD_WB: begin
        ctrl_o.pc_en      = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_wr     = 1'b1;
      end
      S_ST_MEM: begin
        ctrl_o.pc_en  = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OPC_RT = 6'b000000,
  parameter logic [OP_W-1:0] OPC_OI = 6'b001101,
  parameter logic [OP_W-1:0] OPC_LD = 6'b100011,
  parameter logic [OP_W-1:0] OPC_ST = 6'b101011,
  parameter logic [OP_W-1:0] OPC_BR = 6'b000100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            zero_i,
  output logic [ST_W-1:0] state_o,
  output logic            ir_en_o,
  output logic            pc_en_o,
  output logic            pc_sel_o,
  output logic            a_en_o,
  output logic            b_en_o,
  output logic            ext_sign_o,
  output logic            alu_imm_o,
  output logic [1:0]      alu_op_o,
  output logic            r_en_o,
  output logic            mem_rd_o,
  output logic            m_en_o,
  output logic            mem_wr_o,
  output logic            mem_to_reg_o,
  output logic            reg_wr_o,
  output logic            reg_dst_rd_o
);

  cls_e  op_cls;
  st_e   state_q, state_d;
  ctrl_t ctrl_d, ctrl_q, ctrl_rst;

  mcyc_opdec #(
    .OP_W(OP_W), .OPC_RT(OPC_RT), .OPC_OI(OPC_OI),
    .OPC_LD(OPC_LD), .OPC_ST(OPC_ST), .OPC_BR(OPC_BR)
  ) u_opdec (
    .opcode_i (opcode_i),
    .cls_o    (op_cls)
  );

  mcyc_next u_next (
    .state_i (state_q),
    .cls_i   (op_cls),
    .zero_i  (zero_i),
    .next_o  (state_d)
  );

  // Controls are decoded from the next state so the registered bundle
  // lines up with the state register.
  mcyc_outdec u_out_next (
    .state_i (state_d),
    .ctrl_o  (ctrl_d)
  );

  mcyc_outdec u_out_rst (
    .state_i (S_FETCH),
    .ctrl_o  (ctrl_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      ctrl_q  <= ctrl_rst;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign state_o      = state_q;
  assign ir_en_o      = ctrl_q.ir_en;
  assign pc_en_o      = ctrl_q.pc_en;
  assign pc_sel_o     = ctrl_q.pc_sel;
  assign a_en_o       = ctrl_q.a_en;
  assign b_en_o       = ctrl_q.b_en;
  assign ext_sign_o   = ctrl_q.ext_sign;
  assign alu_imm_o    = ctrl_q.alu_imm;
  assign alu_op_o     = ctrl_q.alu_op;
  assign r_en_o       = ctrl_q.r_en;
  assign mem_rd_o     = ctrl_q.mem_rd;
  assign m_en_o       = ctrl_q.m_en;
  assign mem_wr_o     = ctrl_q.mem_wr;
  assign mem_to_reg_o = ctrl_q.mem_to_reg;
  assign reg_wr_o     = ctrl_q.reg_wr;
  assign reg_dst_rd_o = ctrl_q.reg_dst_rd;

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DECODE);

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && op_cls == CL_BR && zero_i) |=> state_q == S_BR_TAKEN);

  a_r4_final_returns: assert property (@(posedge clk) disable iff (rst)
    pc_en_o |=> state_q == S_FETCH);

  a_r7_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));

  a_r8_wb_after_result: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> ($past(r_en_o) || $past(m_en_o)));

  a_r10_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && op_cls == CL_BAD)
      |=> (state_q == S_FETCH && !reg_wr_o && !mem_wr_o && !pc_en_o));

  a_r11_load_steps: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ir_en_o, a_en_o, r_en_o, m_en_o}));

endmodule

// File: tb/test_mcyc_ctrl.sv
module test_mcyc_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode_i = '0;
  logic       zero_i = 1'b0;
  logic [3:0] state_o;
  logic ir_en_o, pc_en_o, pc_sel_o, a_en_o, b_en_o, ext_sign_o, alu_imm_o;
  logic [1:0] alu_op_o;
  logic r_en_o, mem_rd_o, m_en_o, mem_wr_o, mem_to_reg_o, reg_wr_o, reg_dst_rd_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcyc_ctrl i_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode_i(opcode_i), .zero_i(zero_i),
    .state_o(state_o), .ir_en_o(ir_en_o), .pc_en_o(pc_en_o),
    .pc_sel_o(pc_sel_o), .a_en_o(a_en_o), .b_en_o(b_en_o),
    .ext_sign_o(ext_sign_o), .alu_imm_o(alu_imm_o), .alu_op_o(alu_op_o),
    .r_en_o(r_en_o), .mem_rd_o(mem_rd_o), .m_en_o(m_en_o),
    .mem_wr_o(mem_wr_o), .mem_to_reg_o(mem_to_reg_o), .reg_wr_o(reg_wr_o),
    .reg_dst_rd_o(reg_dst_rd_o)
  );

  function automatic logic [15:0] act_ctrl();
    return {ir_en_o, pc_en_o, pc_sel_o, a_en_o, b_en_o, ext_sign_o, alu_imm_o,
            alu_op_o, r_en_o, mem_rd_o, m_en_o, mem_wr_o, mem_to_reg_o,
            reg_wr_o, reg_dst_rd_o};
  endfunction

  // Expected control bundle per state, taken from R2, R5-R8 and R11.
  function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
    logic ir, pe, ps, a, b, sx, im, re, mr, me, mw, m2r, rw, rd;
    logic [1:0] op;
    {ir, pe, ps, a, b, sx, im, re, mr, me, mw, m2r, rw, rd} = '0;
    op = 2'b00;
    case (s)
      4'h0: ir = 1;
      4'h1: begin a = 1; b = 1; end
      4'h2: begin pe = 1; ps = 1; end
      4'h3: pe = 1;
      4'h4: begin op = 2'b10; re = 1; end
      4'h5: begin pe = 1; rw = 1; rd = 1; end
      4'h6: begin im = 1; op = 2'b01; re = 1; end
      4'h7: begin pe = 1; rw = 1; end
      4'h8, 4'hB: begin im = 1; sx = 1; re = 1; end
      4'h9: begin mr = 1; me = 1; end
      4'hA: begin pe = 1; m2r = 1; rw = 1; end
      4'hC: begin pe = 1; mw = 1; end
      default: ;
    endcase
    return {ir, pe, ps, a, b, sx, im, op, re, mr, me, mw, m2r, rw, rd};
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'h0, 4'h1: return "R2";
      4'h2, 4'h3: return "R5";
      4'h4, 4'h6, 4'h8, 4'hB: return "R6";
      4'h9, 4'hC: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (op=%b z=%0b t=%0t)",
               req, act, exp, opcode_i, zero_i, $time);
    end
  endtask

  // One instruction from fetch; expected path and length from R3, R4, R9, R10.
  task automatic run_one(input logic [5:0] op, input logic z);
    logic [3:0] seq [0:4];
    int len, cpi, cyc;
    opcode_i = op;
    zero_i   = z;
    seq[0] = 4'h0; seq[1] = 4'h1; seq[2] = 4'h0; seq[3] = 4'h0; seq[4] = 4'h0;
    case (op)
      6'b000000: begin seq[2] = 4'h4; seq[3] = 4'h5; len = 4; end
      6'b001101: begin seq[2] = 4'h6; seq[3] = 4'h7; len = 4; end
      6'b100011: begin seq[2] = 4'h8; seq[3] = 4'h9; seq[4] = 4'hA; len = 5; end
      6'b101011: begin seq[2] = 4'hB; seq[3] = 4'hC; len = 4; end
      6'b000100: begin seq[2] = z ? 4'h2 : 4'h3; len = 3; end
      default:   len = 2;
    endcase
    cpi = len;
    cyc = 0;
    for (int i = 0; i < 8; i++) begin
      if (i < len) begin
        chk((len == 2 && i == 1) ? "R10" : (i == 2 ? "R3" : "R4"),
            32'(state_o), 32'(seq[i]));
        chk(req_of(seq[i]), 32'(act_ctrl()), 32'(exp_ctrl(seq[i])));
        if (i == 1) chk("R11", 32'(act_ctrl()), 32'(exp_ctrl(4'h1)));
      end
      @(negedge clk);
      cyc++;
      if (state_o == 4'h0) break;
    end
    chk((len == 2) ? "R10" : "R9", 32'(cyc), 32'(cpi));
    chk("R4", 32'(state_o), 32'h0);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode_i = 6'b100011;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1", 32'(state_o), 32'h0);
    chk("R1", 32'(act_ctrl()), 32'(exp_ctrl(4'h0)));
    rst = 1'b0;
    chk("R1", 32'(state_o), 32'h0);

    // Exhaustive sweep over opcode and flag
    for (int op = 0; op < 64; op++) begin
      for (int z = 0; z < 2; z++) begin
        run_one(6'(op), 1'(z));
      end
    end

    // R1: reset in the middle of a load
    opcode_i = 6'b100011;
    repeat (3) @(negedge clk);
    chk("R7", 32'(state_o), 32'h9);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", 32'(state_o), 32'h0);
    chk("R1", 32'(act_ctrl()), 32'(exp_ctrl(4'h0)));
    rst = 1'b0;
    run_one(6'b000100, 1'b1);
    run_one(6'b101011, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule